// File: doc/BRIEF.md
# ADC Result Pair-Subtract and Accumulate Stage

This block sits behind a successive-approximation converter that samples a bank of channels together and hands back one 12-bit unsigned code per channel. For each channel it can pass the code through, or it can combine the channel with its neighbour and report the difference of the two. It can also add up a fixed number of consecutive results and report only the sum. Each channel has its own result register and a one-cycle valid strobe.

Channels pair up by index: channel 2k is the positive input and channel 2k+1 is the negative input of pair k. Only the even member's enable bit turns the pair on. The multiplexed samplers sit above the direct ones in the same index space, so the first and third multiplexed samplers are the even members of their pairs. A differential result can be reported in two's-complement form, or it can be clamped at zero. Averaging never shifts, so software divides the sum itself.

Top module: `adc_diffavg_post`

## Requirements
- R1: While reset is held and after its release, every `res_valid` bit is 0 and every `res_data` word is 0.
- R2: A single-ended channel with averaging off pulses `res_valid[i]` in the cycle after the cycle in which `raw_valid[i]` is sampled. `res_data[i]` then holds the raw code, zero-extended.
- R3: When `diff_en[2k]`=1 and both `raw_valid[2k]` and `raw_valid[2k+1]` are high in the same cycle, channel 2k reports `raw_data[2k]-raw_data[2k+1]`. Channel 2k+1 gives no output while its pair is differential.
- R4: `diff_en` on an odd channel is ignored. Both members of that pair stay single-ended.
- R5: With `sgn_fmt[2k]`=0, a negative pair difference is reported as 0.
- R6: With `sgn_fmt[2k]`=1, the difference is reported as a 17-bit two's-complement value.
- R7: `avg_sel[i]` codes are: 0 means off, 1 means 2 samples, 2 means 4 samples, 3 means 8 samples, and 4 means 16 samples. Codes 5 to 7 also mean off. With N samples, an output appears only on every Nth accepted sample.
- R8: The averaged output is the unshifted sum. Sixteen samples of 4095 give 65520.
- R9: A signed differential sum of sixteen samples of -4095 gives -65520 (17'h10010) without overflow.
- R10: A change in a channel's effective configuration in any cycle clears that channel's partial sum and sample count. A sample presented in that same cycle is discarded.
- R11: Channels accumulate independently. Averaging on one channel does not delay or alter another channel.
- R12: When a pair is differential, a valid on the even channel without a valid on the odd channel in the same cycle is dropped and produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_valid | input | NUM_CH | Per-channel conversion strobe |
| raw_data | input | NUM_CH x RAW_W | Per-channel raw code |
| diff_en | input | NUM_CH | Pair differential enable (read on even channels only) |
| sgn_fmt | input | NUM_CH | Signed format for a differential pair (read on even channels only) |
| avg_sel | input | NUM_CH x 3 | Averaging count code |
| res_valid | output | NUM_CH | One-cycle result strobe |
| res_data | output | NUM_CH x (RAW_W+AVG_LOG2_MAX+1) | Processed result |

## Verification
The bench targets the odd channel of a differential pair. A design that let it run would emit a stray result there. It also sets the enable on an odd channel, where a design that honoured it would corrupt the even neighbour. Full-scale sixteen-sample sums in both polarities check for a narrow or shifting accumulator, which would wrap or divide. Further tests switch the configuration in the middle of an average and present an unpaired even valid. A design that got these wrong would blend stale partial sums or report half of a pair.

// File: rtl/diffavg_pkg.sv
package diffavg_pkg;

   localparam int SEL_W = 3;

   // map averaging code to log2 of the sample count; out-of-range codes disable
   function automatic int unsigned avg_log2(input logic [SEL_W-1:0] code, input int unsigned max_log2);
      if (code >= 1 && int'(code) <= int'(max_log2))
         return int'(code);
      return 0;
   endfunction

endpackage

// File: rtl/diffavg_pair_front.sv
module diffavg_pair_front
   import diffavg_pkg::*;
#(
   parameter int RAW_W = 12,
   parameter int OUT_W = 17
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pos_v,
   input  logic [RAW_W-1:0] pos_d,
   input  logic             neg_v,
   input  logic [RAW_W-1:0] neg_d,
   input  logic             pair_diff,
   input  logic             pair_signed,
   output logic             even_samp_v,
   output logic [OUT_W-1:0] even_val,
   output logic             even_mode_diff,
   output logic             even_mode_sgn,
   output logic             odd_samp_v,
   output logic [OUT_W-1:0] odd_val,
   output logic             odd_suppressed
);

   localparam int DIFF_W = RAW_W + 1;

   logic signed [DIFF_W-1:0] delta;
   logic signed [OUT_W-1:0]  delta_ext;

   always_comb begin
      delta     = $signed({1'b0, pos_d}) - $signed({1'b0, neg_d});
      delta_ext = OUT_W'(delta);
   end

   always_comb begin
      if (pair_diff) begin
         even_samp_v = pos_v & neg_v;
         if (pair_signed)
            even_val = delta_ext;
         else if (delta < 0)
            even_val = '0;
         else
            even_val = delta_ext;
         odd_samp_v = 1'b0;
      end else begin
         even_samp_v = pos_v;
         even_val    = OUT_W'(pos_d);
         odd_samp_v  = neg_v;
      end
      odd_val        = OUT_W'(neg_d);
      even_mode_diff = pair_diff;
      even_mode_sgn  = pair_diff & pair_signed;
      odd_suppressed = pair_diff;
   end

   p_unsigned_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_diff && !pair_signed) |-> !even_val[OUT_W-1]);

   p_diff_span_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_diff && pair_signed) |->
         ($signed(even_val) <= $signed(OUT_W'((1 << RAW_W) - 1)) &&
          $signed(even_val) >= -$signed(OUT_W'((1 << RAW_W) - 1))));

endmodule

// File: rtl/diffavg_accum.sv
module diffavg_accum
   import diffavg_pkg::*;
#(
   parameter int OUT_W        = 17,
   parameter int AVG_LOG2_MAX = 4,
   parameter int MODE_W       = 5
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              samp_v,
   input  logic [OUT_W-1:0]  samp_val,
   input  logic [MODE_W-1:0] mode,
   input  logic [SEL_W-1:0]  sel,
   output logic              out_v,
   output logic [OUT_W-1:0]  out_d
);

   localparam int CNT_W = AVG_LOG2_MAX + 1;

   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  target;
   logic [OUT_W-1:0]  acc_q;
   logic [MODE_W-1:0] mode_q;
   logic              cfg_change;
   logic              last_one;

   always_comb begin
      target     = CNT_W'(1) << avg_log2(sel, AVG_LOG2_MAX);
      cfg_change = (mode != mode_q);
      last_one   = ((cnt_q + CNT_W'(1)) == target);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         acc_q  <= '0;
         mode_q <= '0;
         out_v  <= 1'b0;
         out_d  <= '0;
      end else begin
         out_v  <= 1'b0;
         mode_q <= mode;
         if (cfg_change) begin
            cnt_q <= '0;
            acc_q <= '0;
         end else if (samp_v) begin
            if (last_one) begin
               out_d <= acc_q + samp_val;
               out_v <= 1'b1;
               acc_q <= '0;
               cnt_q <= '0;
            end else begin
               acc_q <= acc_q + samp_val;
               cnt_q <= cnt_q + CNT_W'(1);
            end
         end
      end
   end

   p_out_needs_sample_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_v |-> $past(samp_v));

   p_cfg_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_change |=> (cnt_q == '0 && acc_q == '0 && !out_v));

endmodule

// File: rtl/adc_diffavg_post.sv
module adc_diffavg_post
   import diffavg_pkg::*;
#(
   parameter int NUM_CH       = 16,
   parameter int RAW_W        = 12,
   parameter int AVG_LOG2_MAX = 4
)(
   input  logic                                        clk,
   input  logic                                        rst_n,
   input  logic [NUM_CH-1:0]                           raw_valid,
   input  logic [NUM_CH-1:0][RAW_W-1:0]                raw_data,
   input  logic [NUM_CH-1:0]                           diff_en,
   input  logic [NUM_CH-1:0]                           sgn_fmt,
   input  logic [NUM_CH-1:0][2:0]                      avg_sel,
   output logic [NUM_CH-1:0]                           res_valid,
   output logic [NUM_CH-1:0][RAW_W+AVG_LOG2_MAX:0]     res_data
);

   localparam int OUT_W   = RAW_W + AVG_LOG2_MAX + 1;
   localparam int NUM_PR  = NUM_CH / 2;
   localparam int MODE_W  = 2 + SEL_W;

   if (NUM_CH < 2 || (NUM_CH % 2) != 0) begin : g_bad_ch
      $error("NUM_CH must be even and at least 2");
   end
   if (RAW_W < 2) begin : g_bad_raw
      $error("RAW_W must be at least 2");
   end
   if (AVG_LOG2_MAX < 1 || AVG_LOG2_MAX > 6) begin : g_bad_avg
      $error("AVG_LOG2_MAX must be within 1..6");
   end

   for (genvar p = 0; p < NUM_PR; p++) begin : g_pair
      localparam int EV = 2 * p;
      localparam int OD = 2 * p + 1;

      logic             ev_v, od_v, ev_diff, ev_sgn, od_sup;
      logic [OUT_W-1:0] ev_val, od_val;

      diffavg_pair_front #(.RAW_W(RAW_W), .OUT_W(OUT_W)) u_front (
         .clk            (clk),
         .rst_n          (rst_n),
         .pos_v          (raw_valid[EV]),
         .pos_d          (raw_data[EV]),
         .neg_v          (raw_valid[OD]),
         .neg_d          (raw_data[OD]),
         .pair_diff      (diff_en[EV]),
         .pair_signed    (sgn_fmt[EV]),
         .even_samp_v    (ev_v),
         .even_val       (ev_val),
         .even_mode_diff (ev_diff),
         .even_mode_sgn  (ev_sgn),
         .odd_samp_v     (od_v),
         .odd_val        (od_val),
         .odd_suppressed (od_sup)
      );

      diffavg_accum #(.OUT_W(OUT_W), .AVG_LOG2_MAX(AVG_LOG2_MAX), .MODE_W(MODE_W)) u_acc_even (
         .clk      (clk),
         .rst_n    (rst_n),
         .samp_v   (ev_v),
         .samp_val (ev_val),
         .mode     ({ev_diff, ev_sgn, avg_sel[EV]}),
         .sel      (avg_sel[EV]),
         .out_v    (res_valid[EV]),
         .out_d    (res_data[EV])
      );

      diffavg_accum #(.OUT_W(OUT_W), .AVG_LOG2_MAX(AVG_LOG2_MAX), .MODE_W(MODE_W)) u_acc_odd (
         .clk      (clk),
         .rst_n    (rst_n),
         .samp_v   (od_v),
         .samp_val (od_val),
         .mode     ({od_sup, 1'b0, avg_sel[OD]}),
         .sel      (avg_sel[OD]),
         .out_v    (res_valid[OD]),
         .out_d    (res_data[OD])
      );

      p_odd_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
         diff_en[EV] |=> !res_valid[OD]);

      p_unpaired_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
         (diff_en[EV] && !raw_valid[OD] && avg_sel[EV] == 3'd0) |=> !res_valid[EV]);
   end

endmodule

// File: tb/adc_diffavg_post_test.sv
module adc_diffavg_post_test;

   localparam int NCH = 16;
   localparam int RW  = 12;
   localparam int OW  = 17;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic [NCH-1:0]         raw_valid = '0;
   logic [NCH-1:0][RW-1:0] raw_data = '0;
   logic [NCH-1:0]         diff_en = '0;
   logic [NCH-1:0]         sgn_fmt = '0;
   logic [NCH-1:0][2:0]    avg_sel = '0;
   logic [NCH-1:0]         res_valid;
   logic [NCH-1:0][OW-1:0] res_data;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   adc_diffavg_post #(.NUM_CH(NCH), .RAW_W(RW), .AVG_LOG2_MAX(4)) uut (
      .clk(clk), .rst_n(rst_n), .raw_valid(raw_valid), .raw_data(raw_data),
      .diff_en(diff_en), .sgn_fmt(sgn_fmt), .avg_sel(avg_sel),
      .res_valid(res_valid), .res_data(res_data)
   );

   always #10 clk = ~clk;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // present valids for one clock; returns at the next falling edge with outputs settled
   task automatic trig(input logic [NCH-1:0] vmask);
      raw_valid = vmask;
      @(negedge clk);
      raw_valid = '0;
   endtask

   task automatic setup();
      diff_en = '0; sgn_fmt = '0; avg_sel = '0; raw_data = '0;
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reset();
      chk(res_valid == '0, "R1 valid in reset", 32'(res_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(res_valid == '0, "R1 valid after reset", 32'(res_valid), 0);
      chk(res_data[0] == '0 && res_data[15] == '0, "R1 data after reset", res_data[0], 0);
   endtask

   task automatic t_single();
      setup();
      raw_data[0] = 12'h123; raw_data[5] = 12'hFFF;
      trig(16'h0021);
      chk(res_valid == 16'h0021, "R2 valid mask", 32'(res_valid), 32'h21);
      chk(res_data[0] == 17'h00123, "R2 ch0 data", res_data[0], 32'h123);
      chk(res_data[5] == 17'h00FFF, "R2 ch5 data", res_data[5], 32'hFFF);
      chk(res_valid == 16'h0021, "R2 one cycle later", 0, 0);
      @(negedge clk);
      chk(res_valid == '0, "R2 strobe is one cycle", 32'(res_valid), 0);
   endtask

   task automatic t_diff();
      setup();
      diff_en[2] = 1'b1;
      repeat (2) @(negedge clk);
      raw_data[2] = 12'd3000; raw_data[3] = 12'd1000;
      trig(16'h000C);
      chk(res_valid[2], "R3 even valid", 32'(res_valid), 32'h4);
      chk(!res_valid[3], "R3 odd silent", 32'(res_valid), 32'h4);
      chk(res_data[2] == 17'd2000, "R3 difference", res_data[2], 2000);
   endtask

   task automatic t_odd_ignore();
      setup();
      diff_en[5] = 1'b1; sgn_fmt[5] = 1'b1;
      raw_data[4] = 12'd10; raw_data[5] = 12'd20;
      trig(16'h0030);
      chk(res_valid[5:4] == 2'b11, "R4 both single-ended", 32'(res_valid), 32'h30);
      chk(res_data[4] == 17'd10, "R4 even raw", res_data[4], 10);
      chk(res_data[5] == 17'd20, "R4 odd raw", res_data[5], 20);
   endtask

   task automatic t_sat();
      setup();
      diff_en[2] = 1'b1; sgn_fmt[3] = 1'b1;
      repeat (2) @(negedge clk);
      raw_data[2] = 12'd100; raw_data[3] = 12'd900;
      trig(16'h000C);
      chk(res_valid[2] && res_data[2] == '0, "R5 negative clamps to zero", res_data[2], 0);
   endtask

   task automatic t_signed();
      setup();
      diff_en[2] = 1'b1; sgn_fmt[2] = 1'b1;
      repeat (2) @(negedge clk);
      raw_data[2] = 12'd100; raw_data[3] = 12'd900;
      trig(16'h000C);
      chk(res_valid[2] && res_data[2] == 17'(-800), "R6 signed difference", res_data[2], 32'(17'(-800)));
   endtask

   task automatic t_unpaired();
      setup();
      diff_en[2] = 1'b1;
      repeat (2) @(negedge clk);
      raw_data[2] = 12'd50;
      trig(16'h0004);
      chk(res_valid == '0, "R12 unpaired even dropped", 32'(res_valid), 0);
   endtask

   task automatic t_avg4();
      int early = 0;
      setup();
      avg_sel[6] = 3'd2;
      repeat (2) @(negedge clk);
      for (int k = 0; k < 4; k++) begin
         raw_data[6] = 12'(5 + k);
         trig(16'h0040);
         if (k < 3 && res_valid[6]) early++;
      end
      chk(early == 0, "R7 no output before 4th", early, 0);
      chk(res_valid[6] && res_data[6] == 17'd26, "R7 sum of four", res_data[6], 26);
   endtask

   task automatic t_avg16_max();
      int early = 0;
      setup();
      avg_sel[8] = 3'd4;
      repeat (2) @(negedge clk);
      raw_data[8] = 12'hFFF;
      for (int k = 0; k < 16; k++) begin
         trig(16'h0100);
         if (k < 15 && res_valid[8]) early++;
      end
      chk(early == 0, "R7 no output before 16th", early, 0);
      chk(res_valid[8] && res_data[8] == 17'd65520, "R8 unshifted sum", res_data[8], 65520);
   endtask

   task automatic t_avg16_neg();
      setup();
      diff_en[10] = 1'b1; sgn_fmt[10] = 1'b1; avg_sel[10] = 3'd4;
      repeat (2) @(negedge clk);
      raw_data[10] = 12'd0; raw_data[11] = 12'hFFF;
      for (int k = 0; k < 16; k++) trig(16'h0C00);
      chk(res_valid[10] && res_data[10] == 17'h10010, "R9 signed 16-sum", res_data[10], 32'h10010);
   endtask

   task automatic t_code_off();
      setup();
      avg_sel[7] = 3'd6;
      repeat (2) @(negedge clk);
      raw_data[7] = 12'd77;
      trig(16'h0080);
      chk(res_valid[7] && res_data[7] == 17'd77, "R7 code 6 means off", res_data[7], 77);
   endtask

   task automatic t_cfg_clear();
      int early = 0;
      setup();
      avg_sel[12] = 3'd2;
      repeat (2) @(negedge clk);
      raw_data[12] = 12'd100;
      trig(16'h1000);
      trig(16'h1000);
      avg_sel[12] = 3'd1;
      raw_data[12] = 12'd500;
      trig(16'h1000);
      if (res_valid[12]) early++;
      raw_data[12] = 12'd7;
      trig(16'h1000);
      if (res_valid[12]) early++;
      chk(early == 0, "R10 no output across change", early, 0);
      trig(16'h1000);
      chk(res_valid[12] && res_data[12] == 17'd14, "R10 fresh sum", res_data[12], 14);
   endtask

   task automatic t_indep();
      setup();
      avg_sel[0] = 3'd1;
      repeat (2) @(negedge clk);
      raw_data[0] = 12'd3; raw_data[1] = 12'd9;
      trig(16'h0003);
      chk(res_valid[1:0] == 2'b10, "R11 plain ch fires alone", 32'(res_valid), 2);
      raw_data[1] = 12'd11;
      trig(16'h0003);
      chk(res_valid[1:0] == 2'b11, "R11 both fire", 32'(res_valid), 3);
      chk(res_data[0] == 17'd6 && res_data[1] == 17'd11, "R11 data", res_data[0], 6);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_single();
      t_diff();
      t_odd_ignore();
      t_sat();
      t_signed();
      t_unpaired();
      t_avg4();
      t_avg16_max();
      t_avg16_neg();
      t_code_off();
      t_cfg_clear();
      t_indep();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule